// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer with Dual Reload and Capture

This block is a 16-bit down counter that two 16-bit companion registers, called the first and second reload/capture registers, work alongside. One 3-bit mode field picks its behaviour. In pulse-width mode the counter counts instruction-cycle ticks. When it passes zero it reloads from the two registers in turn, and it can toggle an output pin, so a host sets the high and low times of a waveform separately. In event mode the counter counts rising edges on pin A. In capture mode the counter counts ticks, and an active edge on a pin copies its value into the register that belongs to that pin. The edge polarity of each pin is set by the mode code.

Every mode raises two pending flags, A and B. Each flag has its own enable and drives its own interrupt request. Pin B stays usable as an interrupt source in every mode. A single write port and a combinational read port give access to the counter, the two registers and a control word. Both pin inputs pass through a two-flop synchronizer before edge detection.

A five-state controller sequences the block. STOP is entered from any state when run is low. PWM_TO_B is entered when run is high with a pulse-width code, and it moves to PWM_TO_A on a counter wrap. PWM_TO_A moves back to PWM_TO_B on a counter wrap. EVENT is entered when run is high with an event code. CAPTURE is entered when run is high with a capture code. A mode change while running moves the controller straight to the state for the new mode class.

Top module: `mmt_timer`

## Requirements
- R1: After reset the counter, both registers and the control word read 0, and tog_out, irq_a and irq_b are 0.
- R2: wr_sel/rd_sel encode 0 = counter, 1 = first register, 2 = second register, 3 = control. Control bits: [2:0] mode, [3] run, [4] enable A, [5] enable B, [6] pending A, [7] pending B. Upper bits read 0. A write takes effect at the next clock edge, and a written value reads back.
- R3: While the controller is in STOP (run = 0), the counter changes only by a write.
- R4: Modes 100 and 101 are pulse-width modes. Each tick decrements the counter. A tick at zero loads the second register on the first wrap after start, the first register on the next wrap, and so on alternately. Every wrap sets pending A.
- R5: tog_out inverts on every pulse-width wrap in mode 101. In every other mode it holds its value.
- R6: In pulse-width modes a rising edge on pin B sets pending B.
- R7: Modes 000 and 001 are event modes. Each rising edge on pin A decrements the counter, and tick has no effect. A decrement at zero gives FFFF and sets pending A. A rising edge on pin B sets pending B.
- R8: Modes with bit 1 set are capture modes. Each tick decrements the counter. An active edge on pin A copies the counter into the first register and sets pending A. An active edge on pin B copies it into the second register and sets pending B.
- R9: In capture modes the active edge of pin A is falling when mode bit 2 is 1 and rising otherwise. The active edge of pin B is falling when mode bit 0 is 1 and rising otherwise.
- R10: A pending flag is cleared only by a control write with 0 in its bit. A write of 1 neither sets nor clears it. A hardware set wins over a clear in the same cycle.
- R11: irq_a is pending A AND enable A, and irq_b is pending B AND enable B.
- R12: A pin change takes effect at the third rising clock edge after it and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-cycle count enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 16 | Read data (combinational) |
| pin_a | input | 1 | Pin A input (asynchronous) |
| pin_b | input | 1 | Pin B input (asynchronous) |
| tog_out | output | 1 | Pin A toggle output |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
The hardest state to reach from the ports is the PWM_TO_A / PWM_TO_B alternation, combined with a wrap landing on a zero-valued reload register. In that case the counter reloads zero and wraps again on the very next tick. The bench reaches it by sweeping every pair of small reload values, including zero, in both pulse-width modes. It single-steps the tick input and compares the counter and tog_out against an arithmetic model after every step. Falling-edge capture is reached by raising each pin first, which must leave the registers untouched, and then lowering it.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
    typedef enum logic [2:0] {
        ST_STOP,
        ST_PWM_TO_B,
        ST_PWM_TO_A,
        ST_EVENT,
        ST_CAPTURE
    } mmt_state_e;

    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_RA   = 2'd1;
    localparam logic [1:0] SEL_RB   = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int CB_RUN   = 3;
    localparam int CB_EN_A  = 4;
    localparam int CB_EN_B  = 5;
    localparam int CB_PND_A = 6;
    localparam int CB_PND_B = 7;

    function automatic logic is_pwm(input logic [2:0] m);
        return m[2:1] == 2'b10;
    endfunction

    function automatic logic is_capture(input logic [2:0] m);
        return m[1];
    endfunction
endpackage

// File: rtl/mmt_pin_sync.sv
module mmt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;
    assign fall = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/mmt_mode_fsm.sv
module mmt_mode_fsm
    import mmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] mode,
    input  logic       wrap,
    output logic       pwm_act,
    output logic       ev_act,
    output logic       cap_act,
    output logic       reload_b
);
    mmt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_STOP;
        end else if (is_pwm(mode)) begin
            unique case (state_q)
                ST_PWM_TO_B: state_d = wrap ? ST_PWM_TO_A : ST_PWM_TO_B;
                ST_PWM_TO_A: state_d = wrap ? ST_PWM_TO_B : ST_PWM_TO_A;
                default:     state_d = ST_PWM_TO_B;
            endcase
        end else if (is_capture(mode)) begin
            state_d = ST_CAPTURE;
        end else begin
            state_d = ST_EVENT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        pwm_act  = 1'b0;
        ev_act   = 1'b0;
        cap_act  = 1'b0;
        reload_b = 1'b0;
        unique case (state_q)
            ST_STOP:     ;
            ST_PWM_TO_B: begin pwm_act = 1'b1; reload_b = 1'b1; end
            ST_PWM_TO_A: pwm_act = 1'b1;
            ST_EVENT:    ev_act  = 1'b1;
            ST_CAPTURE:  cap_act = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/mmt_timer.sv
module mmt_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic             tog_out,
    output logic             irq_a,
    output logic             irq_b
);
    localparam int NPINS = 2;
    localparam int CTRL_W = 8;

    logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
    logic [2:0]       mode_q;
    logic             run_q, en_a_q, en_b_q, pnd_a_q, pnd_b_q, tog_q;

    logic [NPINS-1:0] pins, rise, fall;
    assign pins = {pin_b, pin_a};

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            mmt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (pins[p]),
                .rise (rise[p]),
                .fall (fall[p])
            );
        end
    endgenerate

    logic pwm_act, ev_act, cap_act, reload_b;
    logic at_zero, dec, pwm_wrap, a_trig, b_trig;
    logic wr_cnt, wr_ra, wr_rb, wr_ctrl, set_a, set_b;

    assign wr_cnt  = wr_en && (wr_sel == SEL_CNT);
    assign wr_ra   = wr_en && (wr_sel == SEL_RA);
    assign wr_rb   = wr_en && (wr_sel == SEL_RB);
    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

    assign at_zero  = (cnt_q == '0);
    assign a_trig   = mode_q[2] ? fall[0] : rise[0];
    assign b_trig   = mode_q[0] ? fall[1] : rise[1];
    assign dec      = ((pwm_act || cap_act) && tick) || (ev_act && rise[0]);
    assign pwm_wrap = pwm_act && tick && at_zero;

    assign set_a = pwm_wrap || (ev_act && rise[0] && at_zero) || (cap_act && a_trig);
    assign set_b = ((pwm_act || ev_act) && rise[1]) || (cap_act && b_trig);

    mmt_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .mode    (mode_q),
        .wrap    (pwm_wrap),
        .pwm_act (pwm_act),
        .ev_act  (ev_act),
        .cap_act (cap_act),
        .reload_b(reload_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wr_data;
        end else if (dec) begin
            if (pwm_act && at_zero) cnt_q <= reload_b ? rb_q : ra_q;
            else                    cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ra_q <= '0;
            rb_q <= '0;
        end else begin
            if (wr_ra)                  ra_q <= wr_data;
            else if (cap_act && a_trig) ra_q <= cnt_q;
            if (wr_rb)                  rb_q <= wr_data;
            else if (cap_act && b_trig) rb_q <= cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 3'b000;
            run_q   <= 1'b0;
            en_a_q  <= 1'b0;
            en_b_q  <= 1'b0;
            pnd_a_q <= 1'b0;
            pnd_b_q <= 1'b0;
            tog_q   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= wr_data[2:0];
                run_q  <= wr_data[CB_RUN];
                en_a_q <= wr_data[CB_EN_A];
                en_b_q <= wr_data[CB_EN_B];
            end
            if (set_a)                             pnd_a_q <= 1'b1;
            else if (wr_ctrl && !wr_data[CB_PND_A]) pnd_a_q <= 1'b0;
            if (set_b)                             pnd_b_q <= 1'b1;
            else if (wr_ctrl && !wr_data[CB_PND_B]) pnd_b_q <= 1'b0;
            if (pwm_wrap && mode_q == 3'b101)       tog_q <= ~tog_q;
        end
    end

    logic [CTRL_W-1:0] ctrl_word;
    assign ctrl_word = {pnd_b_q, pnd_a_q, en_b_q, en_a_q, run_q, mode_q};

    always_comb begin
        unique case (rd_sel)
            SEL_CNT: rd_data = cnt_q;
            SEL_RA:  rd_data = ra_q;
            SEL_RB:  rd_data = rb_q;
            default: rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_word};
        endcase
    end

    assign tog_out = tog_q;
    assign irq_a   = pnd_a_q & en_a_q;
    assign irq_b   = pnd_b_q & en_b_q;
endmodule

// File: rtl/mmt_timer_chk.sv
module mmt_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic             pwm_act,
    input logic             ev_act,
    input logic             cap_act,
    input logic             a_rise,
    input logic             a_trig,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] ra_q,
    input logic [2:0]       mode_q,
    input logic             tog_q,
    input logic             pnd_a_q
);
    logic wr_cnt, wr_ra, wr_ctrl;
    assign wr_cnt  = wr_en && (wr_sel == 2'd0);
    assign wr_ra   = wr_en && (wr_sel == 2'd1);
    assign wr_ctrl = wr_en && (wr_sel == 2'd3);

    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_act && !ev_act && !cap_act && !wr_cnt) |=> $stable(cnt_q));

    p_tog_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_act && mode_q == 3'b101) |=> $stable(tog_q));

    p_event_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_act && a_rise && !wr_cnt && cnt_q != '0) |=>
            cnt_q == CNT_W'($past(cnt_q) - 1'b1));

    p_event_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_act && a_rise && !wr_cnt && cnt_q == '0) |=> (cnt_q == '1 && pnd_a_q));

    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cap_act && a_trig) && !wr_ra) |=> $stable(ra_q));

    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pnd_a_q && !(wr_ctrl && !wr_data[6])) |=> pnd_a_q);
endmodule

bind mmt_timer mmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .pwm_act(pwm_act),
    .ev_act (ev_act),
    .cap_act(cap_act),
    .a_rise (rise[0]),
    .a_trig (a_trig),
    .cnt_q  (cnt_q),
    .ra_q   (ra_q),
    .mode_q (mode_q),
    .tog_q  (tog_q),
    .pnd_a_q(pnd_a_q)
);

// File: tb/mmt_timer_bench.sv
module mmt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic        tog_out, irq_a, irq_b;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    mmt_timer u_mmt_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_a(pin_a), .pin_b(pin_b),
        .tog_out(tog_out), .irq_a(irq_a), .irq_b(irq_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic step();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] ctl(input logic [2:0] m, input logic run,
                                        input logic ea, input logic eb,
                                        input logic pa, input logic pb);
        return {8'h00, pb, pa, eb, ea, run, m};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] c;
        logic        exp_tog;
        logic        ph_b;
        exp_tog = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            check("R1 reset register", v, 0);
        end
        check("R1 tog_out", tog_out, 0);
        check("R1 irq_a", irq_a, 0);
        check("R1 irq_b", irq_b, 0);

        // R2 readback, R10 write of 1 does not set pending
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'hBEEF);
        wr(2'd0, 16'h0055);
        wr(2'd3, 16'h00F3);
        rd(2'd1, v); check("R2 first register", v, 16'h1234);
        rd(2'd2, v); check("R2 second register", v, 16'hBEEF);
        rd(2'd0, v); check("R2 counter", v, 16'h0055);
        rd(2'd3, v); check("R2/R10 control word", v, 16'h0033);

        // R3 stopped counter ignores ticks
        repeat (5) step();
        rd(2'd0, v); check("R3 stopped counter", v, 16'h0055);

        // R4/R5 pulse-width sweep
        for (int m = 4; m <= 5; m++) begin
            for (int ra = 0; ra < 4; ra++) begin
                for (int rb = 0; rb < 4; rb++) begin
                    wr(2'd3, ctl(3'(m), 0, 1, 0, 0, 0));
                    wr(2'd0, 16'd2);
                    wr(2'd1, 16'(ra));
                    wr(2'd2, 16'(rb));
                    wr(2'd3, ctl(3'(m), 1, 1, 0, 0, 0));
                    c = 16'd2;
                    ph_b = 1'b1;
                    for (int k = 0; k < 10; k++) begin
                        step();
                        if (c == 0) begin
                            c = ph_b ? 16'(rb) : 16'(ra);
                            ph_b = ~ph_b;
                            if (m == 5) exp_tog = ~exp_tog;
                        end else begin
                            c = c - 1'b1;
                        end
                        rd(2'd0, v); check("R4 pwm counter", v, c);
                        check("R5 tog_out", tog_out, exp_tog);
                    end
                    check("R4/R11 wrap pending A irq", irq_a, 1);
                end
            end
        end

        // R6/R12 pin B edge in pulse-width mode, with synchronizer latency
        wr(2'd3, ctl(3'b100, 1, 0, 1, 0, 0));
        pin_b = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R12 no effect at second edge", irq_b, 0);
        @(negedge clk);
        check("R6/R12 pending B at third edge", irq_b, 1);
        pin_b = 1'b0;
        settle();

        // R7 event mode 000
        wr(2'd3, ctl(3'b000, 0, 0, 0, 0, 0));
        wr(2'd0, 16'd1);
        wr(2'd3, ctl(3'b000, 1, 1, 1, 0, 0));
        tick = 1'b1;
        repeat (6) @(negedge clk);
        tick = 1'b0;
        rd(2'd0, v); check("R7 tick ignored in event mode", v, 16'd1);
        pin_a = 1'b1; settle();
        rd(2'd0, v); check("R7 rising edge counts", v, 16'd0);
        check("R7 no pending before wrap", irq_a, 0);
        pin_a = 1'b0; settle();
        rd(2'd0, v); check("R7 falling edge ignored", v, 16'd0);
        pin_a = 1'b1; settle();
        rd(2'd0, v); check("R7 wrap to FFFF", v, 16'hFFFF);
        check("R7 wrap sets pending A", irq_a, 1);
        pin_a = 1'b0; settle();
        pin_b = 1'b1; settle();
        check("R7 pin B sets pending B", irq_b, 1);
        pin_b = 1'b0; settle();

        // R11 enable gates request, pending kept
        wr(2'd3, ctl(3'b000, 1, 0, 1, 1, 1));
        check("R11 irq_a masked", irq_a, 0);
        rd(2'd3, v); check("R10/R11 pending kept", v, 16'h00E8);

        // R7 event mode 001 counts rising edges of A
        wr(2'd3, ctl(3'b001, 0, 0, 0, 0, 0));
        wr(2'd0, 16'd5);
        wr(2'd3, ctl(3'b001, 1, 0, 0, 0, 0));
        pin_a = 1'b1; settle();
        rd(2'd0, v); check("R7 mode 001 rising edge", v, 16'd4);
        pin_a = 1'b0; settle();
        rd(2'd0, v); check("R7 mode 001 falling ignored", v, 16'd4);

        // R8/R9 capture sweep over the four capture codes
        for (int m = 0; m < 8; m++) begin
            logic neg_a, neg_b;
            logic [15:0] c1, c2;
            if (m[1] == 1'b0) continue;
            neg_a = m[2];
            neg_b = m[0];
            c1 = 16'h0100 + 16'(m);
            c2 = 16'h0200 + 16'(m);
            wr(2'd3, ctl(3'(m), 0, 1, 1, 0, 0));
            wr(2'd1, 16'd0);
            wr(2'd2, 16'd0);
            wr(2'd0, c1);
            wr(2'd3, ctl(3'(m), 1, 1, 1, 0, 0));
            pin_a = 1'b1; settle();
            rd(2'd1, v); check("R8/R9 pin A rise", v, neg_a ? 16'd0 : c1);
            wr(2'd0, c2);
            pin_a = 1'b0; settle();
            rd(2'd1, v); check("R8/R9 pin A fall", v, neg_a ? c2 : c1);
            wr(2'd0, c1);
            pin_b = 1'b1; settle();
            rd(2'd2, v); check("R8/R9 pin B rise", v, neg_b ? 16'd0 : c1);
            wr(2'd0, c2);
            pin_b = 1'b0; settle();
            rd(2'd2, v); check("R8/R9 pin B fall", v, neg_b ? c2 : c1);
            rd(2'd3, v); check("R8 capture pendings", v, 16'h00F8 | 16'(m));
            repeat (3) step();
            rd(2'd0, v); check("R8 capture counter ticks", v, c2 - 16'd3);
            wr(2'd3, ctl(3'(m), 1, 1, 1, 1, 1));
            rd(2'd3, v); check("R10 write of one keeps pending", v, 16'h00F8 | 16'(m));
            wr(2'd3, ctl(3'(m), 1, 1, 1, 0, 0));
            rd(2'd3, v); check("R10 write of zero clears", v, 16'h0038 | 16'(m));
        end

        check("R5 tog held outside mode 101", tog_out, exp_tog);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule